// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a cache-line burst on a synchronous memory. On each rising clock edge it samples a base address, two active-low start strobes (one driven by a processor, one by a cache controller), an active-low advance input, a burst-order select and three chip-select inputs. From these it decides whether the edge loads a new base address, steps the burst, holds the current beat (a wait state), deselects the device, or leaves an idle device idle.

The address it presents keeps the upper bits latched at the load edge and replaces the two lowest bits with a value derived from a 2-bit beat counter. The order select chooses between a linear order (the start value counting up, modulo four) and an interleaved order (the start value XOR the beat count). The block also presents the beat count and a flag saying whether the current cycle is selected. The memory array, data path and output timing are handled elsewhere. All pins are plain control and status pins: no data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: A start strobe loads a new burst only when the device is fully selected: `sel_lo_n` low, `sel_hi` high and `sel_aux_n` low together.
- R2: A low `proc_stb_n` while `sel_lo_n` is high is blocked: it starts nothing, and with `ctrl_stb_n` high an active burst keeps its address and follows `adv_n` as if no strobe were present.
- R3: With the device fully selected, a low `ctrl_stb_n` alone, or both strobes low, loads `addr_in` as the new base; `acc_selected` goes high and `burst_cnt` becomes 0 after that edge.
- R4: A live strobe with any select input inactive (either strobe with `sel_lo_n` low, or `ctrl_stb_n` with `sel_lo_n` high) is a deselect cycle: after the edge `acc_selected` is 0 and `burst_cnt` is 0.
- R5: `adv_n` is ignored on an edge that loads a base address: the beat count after a load is 0 whatever `adv_n` was.
- R6: In a selected cycle with both strobes high (or the processor strobe blocked), `adv_n` low increments `burst_cnt` by one modulo 4 and `adv_n` high keeps `burst_cnt` and `acc_addr` unchanged.
- R7: With `order_ilv` low, `acc_addr[1:0]` equals the loaded start bits plus `burst_cnt`, modulo 4 (start 2 gives 2, 3, 0, 1).
- R8: With `order_ilv` high, `acc_addr[1:0]` equals the loaded start bits XOR `burst_cnt` (start 1 gives 1, 0, 3, 2).
- R9: After four advances the beat count is back to 0 and the low address bits are back at the start value.
- R10: `acc_addr[AW-1:2]` changes only on a load edge; it stays at the loaded value through the whole burst and through deselects.
- R11: While reset is asserted and right after it, `acc_selected` is 0, `burst_cnt` is 0 and `acc_addr` is 0.
- R12: A deselected device with both strobes high stays deselected and keeps `burst_cnt` at 0 regardless of `adv_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW | External base address |
| proc_stb_n | input | 1 | Processor start strobe, active low |
| ctrl_stb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait state |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static level) |
| sel_lo_n | input | 1 | Primary chip select, active low; gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_aux_n | input | 1 | Chip select, active low |
| acc_addr | output | AW | Current access address |
| acc_selected | output | 1 | High while the current cycle is selected |
| burst_cnt | output | 2 | Beat count within the burst, 0 to 3 |

## Verification
The assertions assume that `order_ilv` is a static level during a burst and that every input is a clean 0 or 1 at each rising edge; the stimulus changes inputs only at falling edges and switches the order select only while no burst output is being compared against a different order. They also assume the strobes are the only way to leave the deselected state, which the stimulus respects by never expecting `adv_n` to wake an idle device. Sequences cover loads from each strobe, blocked strobes in the middle of a burst with a changed `addr_in`, wait states, full wraps in both orders, and deselects from each inactive select.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic [2:0] {
    ACT_IDLE    = 3'd0,
    ACT_LOAD    = 3'd1,
    ACT_DESEL   = 3'd2,
    ACT_ADVANCE = 3'd3,
    ACT_HOLD    = 3'd4
  } bas_act_e;
endpackage

// File: rtl/bas_decode.sv
module bas_decode
  import bas_pkg::*;
(
  input  logic     proc_stb_n,
  input  logic     ctrl_stb_n,
  input  logic     adv_n,
  input  logic     sel_lo_n,
  input  logic     sel_hi,
  input  logic     sel_aux_n,
  input  logic     active,
  output bas_act_e act
);
  logic full_sel;
  logic proc_live;
  logic ctrl_live;

  assign full_sel  = !sel_lo_n && sel_hi && !sel_aux_n;
  // processor strobe is masked by the primary select
  assign proc_live = !proc_stb_n && !sel_lo_n;
  // controller strobe is honoured with any select state
  assign ctrl_live = !ctrl_stb_n;

  always_comb begin
    if (proc_live || ctrl_live) begin
      act = full_sel ? ACT_LOAD : ACT_DESEL;
    end else if (active) begin
      act = adv_n ? ACT_HOLD : ACT_ADVANCE;
    end else begin
      act = ACT_IDLE;
    end
  end
endmodule

// File: rtl/bas_burst_ctr.sv
module bas_burst_ctr
  import bas_pkg::*;
#(
  parameter int unsigned CW = BEAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bas_act_e      act,
  input  logic [CW-1:0] start_bits,
  input  logic          interleave,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] low_bits
);
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (act)
        ACT_LOAD, ACT_DESEL: cnt_q <= '0;
        ACT_ADVANCE:         cnt_q <= cnt_q + CNT_ONE;
        default:             cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt = cnt_q;

  logic [CW-1:0] lin_bits;
  logic [CW-1:0] ilv_bits;

  assign lin_bits = start_bits + cnt_q;

  genvar gi;
  generate
    for (gi = 0; gi < CW; gi++) begin : g_ilv
      assign ilv_bits[gi] = start_bits[gi] ^ cnt_q[gi];
    end
  endgenerate

  assign low_bits = interleave ? ilv_bits : lin_bits;

  // R9
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_ADVANCE && cnt_q == CNT_TOP) |=> (cnt_q == '0));

  // R6
  hold_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HOLD) |=> $stable(cnt_q));
endmodule

// File: rtl/bas_base_reg.sv
module bas_base_reg
  import bas_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bas_act_e      act,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (act == ACT_LOAD) begin
      base_q <= addr_in;
    end
  end

  assign base = base_q;

  // R10
  base_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act != ACT_LOAD) |=> $stable(base_q));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          proc_stb_n,
  input  logic          ctrl_stb_n,
  input  logic          adv_n,
  input  logic          order_ilv,
  input  logic          sel_lo_n,
  input  logic          sel_hi,
  input  logic          sel_aux_n,
  output logic [AW-1:0] acc_addr,
  output logic          acc_selected,
  output logic [1:0]    burst_cnt
);
  localparam int unsigned CW = BEAT_W;

  bas_act_e      act;
  logic          sel_q;
  logic [AW-1:0] base;
  logic [CW-1:0] cnt;
  logic [CW-1:0] low_bits;

  bas_decode u_decode (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .adv_n      (adv_n),
    .sel_lo_n   (sel_lo_n),
    .sel_hi     (sel_hi),
    .sel_aux_n  (sel_aux_n),
    .active     (sel_q),
    .act        (act)
  );

  bas_base_reg #(.AW(AW)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .addr_in (addr_in),
    .base    (base)
  );

  bas_burst_ctr #(.CW(CW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .start_bits (base[CW-1:0]),
    .interleave (order_ilv),
    .cnt        (cnt),
    .low_bits   (low_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (act == ACT_LOAD) begin
      sel_q <= 1'b1;
    end else if (act == ACT_DESEL) begin
      sel_q <= 1'b0;
    end
  end

  assign acc_addr     = {base[AW-1:CW], low_bits};
  assign acc_selected = sel_q;
  assign burst_cnt    = cnt;

  // R3
  load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_lo_n && sel_hi && !sel_aux_n && (!proc_stb_n || !ctrl_stb_n))
    |=> (acc_selected && burst_cnt == 2'd0 && acc_addr == $past(addr_in)));

  // R4
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!sel_lo_n && !(sel_hi && !sel_aux_n) && (!proc_stb_n || !ctrl_stb_n)) ||
     (sel_lo_n && !ctrl_stb_n))
    |=> (!acc_selected && burst_cnt == 2'd0));

  // R6
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_selected && ctrl_stb_n && (proc_stb_n || sel_lo_n) && !adv_n)
    |=> (burst_cnt == $past(burst_cnt) + 2'd1));

  // R10
  upper_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stb_n && (proc_stb_n || sel_lo_n))
    |=> $stable(acc_addr[AW-1:CW]));

  // R12
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_selected && ctrl_stb_n && (proc_stb_n || sel_lo_n))
    |=> (!acc_selected && burst_cnt == 2'd0));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          proc_stb_n = 1'b1;
  logic          ctrl_stb_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_ilv = 1'b0;
  logic          sel_lo_n = 1'b0;
  logic          sel_hi = 1'b1;
  logic          sel_aux_n = 1'b0;
  logic [AW-1:0] acc_addr;
  logic          acc_selected;
  logic [1:0]    burst_cnt;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  string phase = "R11";

  // reference model state
  int m_sel = 0;
  int m_base = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_in      (addr_in),
    .proc_stb_n   (proc_stb_n),
    .ctrl_stb_n   (ctrl_stb_n),
    .adv_n        (adv_n),
    .order_ilv    (order_ilv),
    .sel_lo_n     (sel_lo_n),
    .sel_hi       (sel_hi),
    .sel_aux_n    (sel_aux_n),
    .acc_addr     (acc_addr),
    .acc_selected (acc_selected),
    .burst_cnt    (burst_cnt)
  );

  function automatic int exp_addr();
    int lo;
    if (order_ilv) lo = (m_base & 3) ^ m_cnt;
    else           lo = ((m_base & 3) + m_cnt) % 4;
    return (m_base & ~3) | lo;
  endfunction

  task automatic check(input string req, input int act_v, input int exp_v, input string what);
    n_checks++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act_v, exp_v, $time);
    end
  endtask

  // cycle-by-cycle model and comparison
  always @(posedge clk) begin
    bit full;
    if (!rst_n) begin
      m_sel = 0; m_cnt = 0; m_base = 0;
    end else begin
      full = !sel_lo_n && sel_hi && !sel_aux_n;
      if ((!proc_stb_n && !sel_lo_n) || !ctrl_stb_n) begin
        if (full) begin
          m_sel = 1; m_cnt = 0; m_base = int'(addr_in);
        end else begin
          m_sel = 0; m_cnt = 0;
        end
      end else if (m_sel != 0 && !adv_n) begin
        m_cnt = (m_cnt + 1) % 4;
      end
    end
    #1;
    check(phase, int'(acc_selected), m_sel, "acc_selected");
    check(phase, int'(burst_cnt), m_cnt, "burst_cnt");
    check(phase, int'(acc_addr), exp_addr(), "acc_addr");
  end

  task automatic drive(input logic p, input logic c, input logic a, input logic [AW-1:0] ad);
    @(negedge clk);
    proc_stb_n = p; ctrl_stb_n = c; adv_n = a; addr_in = ad;
  endtask

  task automatic expect_out(input string req, input int sel, input int cnt, input int addr);
    @(posedge clk); #1;
    check(req, int'(acc_selected), sel, "acc_selected");
    check(req, int'(burst_cnt), cnt, "burst_cnt");
    check(req, int'(acc_addr), addr, "acc_addr");
  endtask

  initial begin
    // R11: reset state
    #1;
    check("R11", int'(acc_selected), 0, "acc_selected in reset");
    check("R11", int'(burst_cnt), 0, "burst_cnt in reset");
    check("R11", int'(acc_addr), 0, "acc_addr in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: idle with advance low stays deselected
    phase = "R12";
    drive(1, 1, 0, 20'h12345);
    expect_out("R12", 0, 0, 0);
    expect_out("R12", 0, 0, 0);

    // R5 R7: processor load, adv low on load edge ignored, linear order from 2
    phase = "R7";
    drive(0, 1, 0, 20'hABCD6);
    expect_out("R5", 1, 0, 20'hABCD6);
    drive(1, 1, 0, 20'h00000);
    expect_out("R7", 1, 1, 20'hABCD7);
    expect_out("R7", 1, 2, 20'hABCD4);
    expect_out("R7", 1, 3, 20'hABCD5);
    // R9: fourth advance wraps
    expect_out("R9", 1, 0, 20'hABCD6);

    // R6: wait states hold
    phase = "R6";
    drive(1, 1, 1, 20'h55555);
    expect_out("R6", 1, 0, 20'hABCD6);
    expect_out("R6", 1, 0, 20'hABCD6);
    drive(1, 1, 0, 20'h55555);
    expect_out("R6", 1, 1, 20'hABCD7);

    // R8: interleaved order from start 1
    phase = "R8";
    drive(1, 1, 1, 20'h55555);
    @(negedge clk);
    order_ilv = 1'b1;
    drive(0, 1, 1, 20'h31F01);
    expect_out("R8", 1, 0, 20'h31F01);
    drive(1, 1, 0, 20'h00000);
    expect_out("R8", 1, 1, 20'h31F00);
    expect_out("R8", 1, 2, 20'h31F03);
    expect_out("R8", 1, 3, 20'h31F02);
    expect_out("R9", 1, 0, 20'h31F01);

    // R2 R10: processor strobe blocked by sel_lo_n high, burst continues
    phase = "R2";
    @(negedge clk);
    sel_lo_n = 1'b1; proc_stb_n = 1'b0; adv_n = 1'b0; addr_in = 20'hFFFFC;
    expect_out("R2", 1, 1, 20'h31F00);
    expect_out("R10", 1, 2, 20'h31F03);
    @(negedge clk);
    adv_n = 1'b1;
    expect_out("R2", 1, 2, 20'h31F03);

    // R3: controller strobe alone loads, then both strobes low
    phase = "R3";
    @(negedge clk);
    sel_lo_n = 1'b0; proc_stb_n = 1'b1; ctrl_stb_n = 1'b0; adv_n = 1'b0;
    addr_in = 20'h0C0DE; order_ilv = 1'b0;
    expect_out("R3", 1, 0, 20'h0C0DE);
    drive(1, 1, 0, 20'h0);
    expect_out("R3", 1, 1, 20'h0C0DF);
    drive(0, 0, 1, 20'h77773);
    expect_out("R3", 1, 0, 20'h77773);

    // R4 R1: strobe with sel_hi low deselects, no load
    phase = "R4";
    @(negedge clk);
    proc_stb_n = 1'b0; ctrl_stb_n = 1'b1; sel_hi = 1'b0; addr_in = 20'h11110;
    expect_out("R4", 0, 0, 20'h77773);
    @(negedge clk);
    proc_stb_n = 1'b1; sel_hi = 1'b1; adv_n = 1'b0;
    expect_out("R12", 0, 0, 20'h77773);
    // R1: sel_aux_n high blocks a controller-strobe load
    @(negedge clk);
    ctrl_stb_n = 1'b0; sel_aux_n = 1'b1; addr_in = 20'h22220;
    expect_out("R1", 0, 0, 20'h77773);
    // reload, then controller strobe with sel_lo_n high deselects
    @(negedge clk);
    sel_aux_n = 1'b0; addr_in = 20'h44442; adv_n = 1'b1;
    expect_out("R3", 1, 0, 20'h44442);
    @(negedge clk);
    sel_lo_n = 1'b1; addr_in = 20'h99990;
    expect_out("R4", 0, 0, 20'h44442);
    @(negedge clk);
    ctrl_stb_n = 1'b1; sel_lo_n = 1'b0;
    expect_out("R12", 0, 0, 20'h44442);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule